// File: doc/BRIEF.md
# Single-Precision Float Operand Splitter

This block takes a 32-bit single-precision floating-point word, supplied as a high and a low 16-bit half, and breaks it into the fields an arithmetic datapath works on. It produces the sign, the biased exponent and a left-justified 32-bit significand. In the significand the hidden leading one is written out, the 23 stored fraction bits follow it, and eight zero guard bits sit at the bottom. The result can go straight into an adder or a multiplier, or it can be put back together unchanged.

Operands that the fast path cannot handle are flagged rather than decoded. These are infinities and NaNs (exponent all ones) and denormals (exponent zero with a nonzero fraction). The caller then hands the operation to a software handler. A word is taken in when the valid strobe is high. Its fields appear together with a done strobe one clock later.

The controller is a two-state machine. `ST_IDLE` waits with done low. An input word with valid high takes either state to `ST_EMIT` and loads the word. `ST_EMIT` drives done high for one cycle. From `ST_EMIT` the machine goes back to `ST_IDLE` when valid is low, or stays in `ST_EMIT` when valid is high, so back-to-back operands are accepted every cycle.

Top module: `fp_operand_split`

## Requirements
- R1: `out_sign` equals bit 31 of the captured word `{word_hi, word_lo}`, for every class of operand.
- R2: For a supported operand, `out_exp` equals bits 30..23 of the captured word as an unsigned biased value.
- R3: For a nonzero, non-all-ones exponent, `out_frac` is {1'b1, word bits 22..0, 8'b0}: the leading bit is at position 31 and the stored fraction is at positions 30..8.
- R4: A word with exponent 0 and fraction 0 is a supported zero. `out_frac` and `out_exp` are 0, `out_unsupported` is 0 and the sign is kept.
- R5: An exponent of 255 sets `out_unsupported`, and `out_exp` and `out_frac` are driven to 0.
- R6: An exponent of 0 with a nonzero fraction sets `out_unsupported`, and `out_exp` and `out_frac` are driven to 0.
- R7: For a supported operand, {out_sign, out_exp, out_frac[30:8]} rebuilds the captured 32-bit word exactly.
- R8: `out_done` is high in exactly the cycle after each cycle in which `in_valid` is high. Back-to-back valid cycles give back-to-back done cycles.
- R9: After reset, `out_done`, `out_unsupported`, `out_exp`, `out_frac` and `out_sign` are all 0.
- R10: The 8 guard bits `out_frac[7:0]` are always 0.
- R11: While `in_valid` is low, changes on `word_hi`/`word_lo` leave every field output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word present on the halves this cycle |
| word_hi | input | 16 | Upper half of the operand (sign, exponent, top fraction bits) |
| word_lo | input | 16 | Lower half of the operand |
| out_sign | output | 1 | Operand sign |
| out_exp | output | 8 | Biased exponent, zero when unsupported |
| out_frac | output | 32 | Left-justified significand with explicit leading bit |
| out_unsupported | output | 1 | Operand is infinity, NaN or denormal |
| out_done | output | 1 | Fields valid for the word taken in the previous cycle |

## Verification
The bench builds the block with its default widths: an 8-bit exponent, a 23-bit stored fraction and 8 guard bits. With these widths the two exponent limits, 0 and 255, can be reached with directed words. The sign and exponent lie entirely in the upper half, and the fraction spans both halves, so a half swapped or mis-wired shows up at once. Directed corner words (signed zeros, infinities, NaNs, the smallest and largest denormal and normal values) are followed by a pseudo-random stream sent both back to back and with gaps. The gaps are used to change the halves while valid is low.

// File: rtl/fp_split_pkg.sv
package fp_split_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } split_state_t;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_NORMAL  = 2'd1,
        CLS_SUBNORM = 2'd2,
        CLS_SPECIAL = 2'd3
    } operand_class_t;

endpackage

// File: rtl/fp_split_fields.sv
module fp_split_fields #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  exp_raw,
    output logic [FRAC_W-1:0] frac_raw
);

    always_comb begin
        sign     = word[WORD_W-1];
        exp_raw  = word[WORD_W-2 -: EXP_W];
        frac_raw = word[FRAC_W-1:0];
    end

endmodule

// File: rtl/fp_split_classify.sv
module fp_split_classify
    import fp_split_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_raw,
    input  logic [FRAC_W-1:0] frac_raw,
    output operand_class_t    cls
);

    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    always_comb begin
        exp_zero  = (exp_raw == '0);
        exp_ones  = &exp_raw;
        frac_zero = (frac_raw == '0);
        if (exp_ones) begin
            cls = CLS_SPECIAL;
        end else if (exp_zero && !frac_zero) begin
            cls = CLS_SUBNORM;
        end else if (exp_zero) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/fp_split_align.sv
module fp_split_align
    import fp_split_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 8,
    localparam int SIG_W  = 1 + FRAC_W + GUARD_W
) (
    input  operand_class_t    cls,
    input  logic [EXP_W-1:0]  exp_raw,
    input  logic [FRAC_W-1:0] frac_raw,
    output logic [EXP_W-1:0]  exp_out,
    output logic [SIG_W-1:0]  sig_out,
    output logic              unsupported
);

    logic                    lead_bit;
    logic [SIG_W-1:0]        sig_full;

    generate
        if (GUARD_W > 0) begin : g_guard
            always_comb sig_full = {lead_bit, frac_raw, {GUARD_W{1'b0}}};
        end else begin : g_noguard
            always_comb sig_full = {lead_bit, frac_raw};
        end
    endgenerate

    always_comb begin
        lead_bit    = 1'b0;
        exp_out     = '0;
        sig_out     = '0;
        unsupported = 1'b0;
        unique case (cls)
            CLS_NORMAL: begin
                lead_bit = 1'b1;
                exp_out  = exp_raw;
                sig_out  = sig_full;
            end
            CLS_ZERO: begin
                lead_bit = 1'b0;
                sig_out  = sig_full;
            end
            CLS_SUBNORM, CLS_SPECIAL: begin
                unsupported = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fp_split_ctrl.sv
module fp_split_ctrl
    import fp_split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic capture_en,
    output logic done
);

    split_state_t state_q;
    split_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture_en = in_valid;
            end
            ST_EMIT: begin
                done       = 1'b1;
                capture_en = in_valid;
            end
            default: ;
        endcase
    end

    // R8: a strobe is answered in the very next cycle
    assert_emit_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (state_q == ST_EMIT));
    assert_idle_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (state_q == ST_IDLE));

endmodule

// File: rtl/fp_operand_split.sv
module fp_operand_split
    import fp_split_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 8,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int HALF_W = WORD_W / 2,
    localparam int SIG_W  = 1 + FRAC_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] word_hi,
    input  logic [HALF_W-1:0] word_lo,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [SIG_W-1:0]  out_frac,
    output logic              out_unsupported,
    output logic              out_done
);

    logic              capture_en;
    logic [WORD_W-1:0] word_q;
    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac_raw;
    operand_class_t    cls;

    fp_split_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .capture_en(capture_en),
        .done      (out_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture_en) begin
            word_q <= {word_hi, word_lo};
        end
    end

    fp_split_fields #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fields (
        .word    (word_q),
        .sign    (out_sign),
        .exp_raw (exp_raw),
        .frac_raw(frac_raw)
    );

    fp_split_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .exp_raw (exp_raw),
        .frac_raw(frac_raw),
        .cls     (cls)
    );

    fp_split_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_align (
        .cls        (cls),
        .exp_raw    (exp_raw),
        .frac_raw   (frac_raw),
        .exp_out    (out_exp),
        .sig_out    (out_frac),
        .unsupported(out_unsupported)
    );

    assert_done_follows_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    assert_repack_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_unsupported ||
            ({out_sign, out_exp, out_frac[SIG_W-2:GUARD_W]} == $past({word_hi, word_lo}))));
    assert_sign_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sign == $past(word_hi[HALF_W-1])));
    assert_lead_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_unsupported |-> (out_frac[SIG_W-1] == (out_exp != '0)));
    assert_unsup_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_unsupported |-> (out_exp == '0 && out_frac == '0));
    assert_guard_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_frac[0] == 1'b0 && (GUARD_W == 0 || out_frac[GUARD_W > 0 ? GUARD_W-1 : 0] == 1'b0));
    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_exp) && $stable(out_frac) && $stable(out_sign)
                       && $stable(out_unsupported)));

endmodule

// File: tb/sim_fp_operand_split.sv
module sim_fp_operand_split;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] word_hi = '0;
    logic [15:0] word_lo = '0;
    logic        out_sign;
    logic [7:0]  out_exp;
    logic [31:0] out_frac;
    logic        out_unsupported;
    logic        out_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit hold_phase = 1'b0;
    bit finished = 1'b0;

    // reference state
    logic [31:0] m_word = '0;
    bit          m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_operand_split u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .word_hi(word_hi), .word_lo(word_lo),
        .out_sign(out_sign), .out_exp(out_exp), .out_frac(out_frac),
        .out_unsupported(out_unsupported), .out_done(out_done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word = '0;
            m_done = 1'b0;
        end else begin
            m_done = in_valid;
            if (in_valid) m_word = {word_hi, word_lo};
        end
    end

    task automatic compare_all();
        int          e;
        logic [31:0] f;
        bit          special, sub, unsup;
        logic [31:0] eexp, efrac;
        string       rexp, rfrac, rcls;
        e       = int'((m_word >> 23) & 32'hFF);
        f       = m_word & 32'h007F_FFFF;
        special = (e == 255);
        sub     = (e == 0) && (f != 0);
        unsup   = special || sub;
        eexp    = unsup ? 32'd0 : 32'(e);
        efrac   = unsup ? 32'd0 : ((e != 0) ? (32'h8000_0000 | (f << 8)) : 32'd0);
        rcls    = special ? "R5" : (sub ? "R6" : ((e == 0) ? "R4" : "R3"));
        rexp    = unsup ? rcls : ((e == 0) ? "R4" : "R2");
        rfrac   = rcls;
        if (hold_phase) begin
            rexp  = "R11";
            rfrac = "R11";
        end
        chk("R8", "done", 32'(out_done), 32'(m_done));
        chk("R1", "sign", 32'(out_sign), 32'(m_word[31]));
        chk(rexp, "exp", 32'(out_exp), eexp);
        chk(rfrac, "frac", out_frac, efrac);
        chk(rcls, "unsupported", 32'(out_unsupported), 32'(unsup));
        chk("R10", "guard", 32'(out_frac[7:0]), 32'd0);
        if (m_done && !unsup)
            chk("R7", "repack", {out_sign, out_exp, out_frac[30:8]}, m_word);
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) compare_all();
    end

    task automatic send(logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        word_hi  = w[31:16];
        word_lo  = w[15:0];
    endtask

    task automatic gap(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports
        chk("R9", "done", 32'(out_done), 32'd0);
        chk("R9", "unsupported", 32'(out_unsupported), 32'd0);
        chk("R9", "exp", 32'(out_exp), 32'd0);
        chk("R9", "frac", out_frac, 32'd0);
        chk("R9", "sign", 32'(out_sign), 32'd0);

        // directed corner words
        send(32'h3F80_0000);  // 1.0 (R3)
        send(32'hC020_0000);  // -2.5
        gap(1);
        send(32'h0000_0000);  // +0 (R4)
        send(32'h8000_0000);  // -0 keeps sign (R4)
        send(32'h7F80_0000);  // +inf (R5)
        send(32'hFFC0_0001);  // NaN (R5)
        send(32'h0000_0001);  // smallest denormal (R6)
        send(32'h807F_FFFF);  // largest denormal (R6)
        send(32'h7F7F_FFFF);  // largest normal
        send(32'h0080_0000);  // smallest normal
        send(32'hFF7F_FFFF);
        gap(2);

        // R11: toggle halves without valid, outputs must hold
        hold_phase = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            word_hi  = 16'h7F80 ^ 16'(i * 16'h1357);
            word_lo  = 16'hBEEF + 16'(i);
        end
        @(negedge clk);
        hold_phase = 1'b0;

        // pseudo-random stream, mixing bursts and gaps
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'd0) send({lfsr[31], 8'hFF, lfsr[22:0]});
            else if (lfsr[3:0] == 4'd1) send({lfsr[31], 8'h00, lfsr[22:0]});
            else send(lfsr);
            if (lfsr[7:5] == 3'd0) gap(1);
        end
        gap(3);
        finish_run();
    end

endmodule